// File: doc/BRIEF.md
# Reset and clock gear controller

This block turns a noisy, active-low reset pin into a clean internal reset for a small microcontroller. The pin passes through a synchronizer and must then stay low for a minimum run of clock cycles before the chip treats it as a real reset. Shorter pulses are ignored. A power-on reset input forces the internal reset at once, with no qualification, and also acts as the asynchronous reset of every flop in the block.

When the internal reset releases, the block latches the clock-source choice from a strap pin. It also restores the internal clock gear to divide-by-8. Software can then select another divide ratio through a one-cycle write port, and the block accepts only the power-of-two ratios 1, 2, 4 and 8.

The block drives the following static or reset-time signals:
- a constant reset-vector address for the core;
- a clear strobe for the peripheral registers;
- a force signal that returns every port pin to its general-purpose setting while reset is held.

None of its outputs reaches on-chip RAM, so RAM contents survive a pin reset.

Top module: `rst_gear_ctrl`

## Requirements
- R1: A low pulse on `rst_pin_n` that is sampled low on fewer than 12 consecutive rising clock edges leaves `core_rst_n` high, and leaves `gear_code` and `clk_sel_ext` unchanged.
- R2: If `rst_pin_n` is sampled low on 12 or more consecutive edges, starting at edge 1, then `core_rst_n` goes low on edge 14. The 14 edges are 2 synchronizer stages plus 12 qualifying samples.
- R3: If `rst_pin_n` is first sampled high again on edge r, `core_rst_n` returns high on edge r+2. It stays low on every edge before that.
- R4: `clk_sel_ext` takes the level of `pll_off` on the edge where `core_rst_n` returns high, with 0 selecting the PLL clock and 1 selecting the external clock. It stays fixed while `core_rst_n` remains high, whatever `pll_off` does.
- R5: After any reset, `gear_code` reads 8, meaning divide-by-8.
- R6: While `core_rst_n` is high, a write with `gear_we`=1 and a `gear_wdata` of 1, 2, 4 or 8 appears on `gear_code` after the next rising edge.
- R7: A write with any other `gear_wdata` value is ignored, and so is any write made while `core_rst_n` is low.
- R8: `reset_vector` always reads 0xBFC0_0000.
- R9: `periph_clr` and `port_gp_force` are high exactly when `core_rst_n` is low.
- R10: Driving `por_n` low asynchronously forces `core_rst_n` low and `gear_code` to 8. If `rst_pin_n` is high, `core_rst_n` goes high on the third rising edge after `por_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Raw external reset pin, active low |
| pll_off | input | 1 | Clock-source strap: 0 selects PLL, 1 selects external clock |
| gear_we | input | 1 | Gear register write enable |
| gear_wdata | input | 4 | Requested divide ratio |
| core_rst_n | output | 1 | Qualified internal reset, active low |
| clk_sel_ext | output | 1 | Latched clock-source select |
| gear_code | output | 4 | Current divide ratio (1, 2, 4 or 8) |
| reset_vector | output | 32 | Core reset and NMI vector address |
| periph_clr | output | 1 | Clear strobe for peripheral registers |
| port_gp_force | output | 1 | Forces port pins to general-purpose mode |

## Verification
A qualification counter that is off by one shows up at the ports within 14 cycles of a pin pulse. A pulse of 11 or 12 samples then either resets the chip or is wrongly ignored, and the edge on which `core_rst_n` falls moves. That is why the bench sweeps every pulse length from 1 to 20. A wrong gear or clock-select register appears on `gear_code` or `clk_sel_ext` one edge after the write or release that exposes it. The bench therefore sweeps all 16 write codes twice from different starting values and toggles the strap after each release.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  localparam int GEAR_W = 4;
  typedef logic [GEAR_W-1:0] gear_t;
  localparam gear_t GEAR_DIV8 = gear_t'(8);

  // A legal ratio is a single set bit: 1, 2, 4 or 8.
  function automatic logic gear_legal(gear_t code);
    return ($countones(code) == 1);
  endfunction
endpackage

// File: rtl/rgc_sync.sv
module rgc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[g] <= RESET_VAL;
        else         chain_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rgc_qualify.sv
module rgc_qualify #(
  parameter int QUAL_CYCLES = 12
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_low,      // synchronized pin is asserted
  output logic in_rst,       // internal reset, active high
  output logic release_now   // this edge ends the internal reset
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_q, rst_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = pin_low && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q;
    if (!pin_low)    cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;

    rst_d = rst_q;
    if (!pin_low)              rst_d = 1'b0;
    else if (cnt_d == CNT_MAX) rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign in_rst      = rst_q;
  assign release_now = rst_q && !pin_low;
endmodule

// File: rtl/rgc_gear.sv
module rgc_gear
  import rgc_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  in_rst,
  input  logic  release_now,
  input  logic  pll_off,
  input  logic  we,
  input  gear_t wdata,
  output gear_t gear,
  output logic  sel_ext
);
  gear_t gear_q, gear_d;
  logic  sel_q, sel_d;
  logic  wr_en;

  always_comb begin
    wr_en  = we && !in_rst && gear_legal(wdata);
    gear_d = gear_q;
    if (in_rst)     gear_d = GEAR_DIV8;
    else if (wr_en) gear_d = wdata;

    sel_d = sel_q;
    if (release_now) sel_d = pll_off;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      gear_q <= GEAR_DIV8;
      sel_q  <= 1'b0;
    end else begin
      gear_q <= gear_d;
      sel_q  <= sel_d;
    end
  end

  assign gear    = gear_q;
  assign sel_ext = sel_q;
endmodule

// File: rtl/rst_gear_ctrl.sv
module rst_gear_ctrl #(
  parameter int          QUAL_CYCLES = 12,
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 32,
  parameter logic [31:0] RESET_VEC   = 32'hBFC0_0000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_pin_n,
  input  logic             pll_off,
  input  logic             gear_we,
  input  logic [3:0]       gear_wdata,
  output logic             core_rst_n,
  output logic             clk_sel_ext,
  output logic [3:0]       gear_code,
  output logic [VEC_W-1:0] reset_vector,
  output logic             periph_clr,
  output logic             port_gp_force
);
  import rgc_pkg::*;

  logic pin_sync;
  logic in_rst;
  logic release_now;

  // Reset value 0 keeps reset held after power-on until the pin is seen high.
  rgc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (rst_pin_n),
    .q      (pin_sync)
  );

  rgc_qualify #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk         (clk),
    .arst_n      (por_n),
    .pin_low     (!pin_sync),
    .in_rst      (in_rst),
    .release_now (release_now)
  );

  rgc_gear u_gear (
    .clk         (clk),
    .arst_n      (por_n),
    .in_rst      (in_rst),
    .release_now (release_now),
    .pll_off     (pll_off),
    .we          (gear_we),
    .wdata       (gear_wdata),
    .gear        (gear_code),
    .sel_ext     (clk_sel_ext)
  );

  assign core_rst_n    = !in_rst;
  assign periph_clr    = in_rst;
  assign port_gp_force = in_rst;
  assign reset_vector  = VEC_W'(RESET_VEC);
endmodule

// File: rtl/rgc_checker.sv
module rgc_checker #(
  parameter int QUAL_CYCLES = 12
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_pin_n,
  input logic       gear_we,
  input logic [3:0] gear_wdata,
  input logic       core_rst_n,
  input logic       clk_sel_ext,
  input logic [3:0] gear_code,
  input logic       periph_clr,
  input logic       port_gp_force
);
  localparam int RUN_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(QUAL_CYCLES);

  // Consecutive raw low samples of the pin, saturating.
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               low_run <= '0;
    else if (rst_pin_n)       low_run <= '0;
    else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
  end

  // R1, R2: reset only after a full qualifying run.
  a_r2_qualified_entry: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst_n) |-> ($past(low_run, 2) == RUN_MAX));

  a_r3_release_follows_pin: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> $past(rst_pin_n, 3));

  a_r4_select_held: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && $past(core_rst_n)) |-> $stable(clk_sel_ext));

  a_r5_gear_div8_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    (!core_rst_n && $past(!core_rst_n)) |-> (gear_code == 4'd8));

  a_r6_gear_onehot: assert property (@(posedge clk) disable iff (!por_n)
    $countones(gear_code) == 1);

  a_r7_illegal_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && gear_we && ($countones(gear_wdata) != 1)) |=> $stable(gear_code));

  a_r9_clear_tracks_reset: assert property (@(posedge clk) disable iff (!por_n)
    (periph_clr != core_rst_n) && (port_gp_force != core_rst_n));
endmodule

bind rst_gear_ctrl rgc_checker #(.QUAL_CYCLES(QUAL_CYCLES)) u_rgc_checker (
  .clk           (clk),
  .por_n         (por_n),
  .rst_pin_n     (rst_pin_n),
  .gear_we       (gear_we),
  .gear_wdata    (gear_wdata),
  .core_rst_n    (core_rst_n),
  .clk_sel_ext   (clk_sel_ext),
  .gear_code     (gear_code),
  .periph_clr    (periph_clr),
  .port_gp_force (port_gp_force)
);

// File: tb/test_rst_gear_ctrl.sv
module test_rst_gear_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        por_n, rst_pin_n, pll_off, gear_we;
  logic [3:0]  gear_wdata;
  logic        core_rst_n, clk_sel_ext, periph_clr, port_gp_force;
  logic [3:0]  gear_code;
  logic [31:0] reset_vector;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_gear_ctrl i_rst_gear_ctrl (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .pll_off(pll_off),
    .gear_we(gear_we), .gear_wdata(gear_wdata), .core_rst_n(core_rst_n),
    .clk_sel_ext(clk_sel_ext), .gear_code(gear_code), .reset_vector(reset_vector),
    .periph_clr(periph_clr), .port_gp_force(port_gp_force)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic write_gear(input logic [3:0] code);
    gear_we = 1'b1; gear_wdata = code;
    @(negedge clk);
    gear_we = 1'b0;
  endtask

  function automatic bit legal(input int c);
    return (c != 0) && ((c & (c - 1)) == 0) && (c < 16);
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_pin_n = 1'b1; pll_off = 1'b0; gear_we = 1'b0; gear_wdata = '0;
    #(CLK_PERIOD * 2 + 1);
    // Reset state
    chk(core_rst_n == 1'b0, "R10 reset state core_rst_n", core_rst_n, 0);
    chk(gear_code == 4'd8, "R5 reset state gear", gear_code, 8);
    chk(periph_clr && port_gp_force, "R9 reset state clear", {periph_clr, port_gp_force}, 3);
    chk(reset_vector == 32'hBFC0_0000, "R8 vector", reset_vector, 32'hBFC0_0000);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(core_rst_n == 1'b0, "R10 held two edges after por", core_rst_n, 0);
    @(negedge clk);
    chk(core_rst_n == 1'b1, "R10 release on third edge", core_rst_n, 1);
    chk(clk_sel_ext == 1'b0, "R4 PLL selected", clk_sel_ext, 0);

    // Gear write sweep, two passes from different start values
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) write_gear(4'd1);
      for (int c = 0; c < 16; c++) begin
        automatic int start = gear_code;
        automatic int exp = legal(c) ? c : start;
        write_gear(4'(c));
        if (legal(c)) chk(gear_code == exp, "R6 legal gear write", gear_code, exp);
        else          chk(gear_code == exp, "R7 illegal gear ignored", gear_code, exp);
      end
    end

    // Pulse-length sweep across the qualification boundary
    for (int len = 1; len <= 20; len++) begin
      automatic int fall_at = 0;
      automatic int rise_at = 0;
      automatic int clr_bad = 0;
      automatic logic prev_sel;
      automatic logic exp_sel = logic'(len % 2);
      write_gear(4'd2);
      pll_off  = exp_sel;
      prev_sel = clk_sel_ext;
      rst_pin_n = 1'b0;
      for (int i = 1; i <= len + 12; i++) begin
        @(negedge clk);
        if (!core_rst_n && fall_at == 0) fall_at = i;
        if (core_rst_n && fall_at != 0 && rise_at == 0) rise_at = i;
        if (periph_clr !== !core_rst_n || port_gp_force !== !core_rst_n) clr_bad++;
        // Writes attempted while reset is held must be dropped (R7).
        gear_we = !core_rst_n; gear_wdata = 4'd4;
        if (i == len) rst_pin_n = 1'b1;
      end
      gear_we = 1'b0;
      chk(clr_bad == 0, "R9 clear strobe tracks reset", clr_bad, 0);
      if (len < 12) begin
        chk(fall_at == 0, "R1 short pulse ignored", fall_at, 0);
        chk(gear_code == 4'd2, "R1 gear kept", gear_code, 2);
        chk(clk_sel_ext == prev_sel, "R1 select kept", clk_sel_ext, prev_sel);
      end else begin
        chk(fall_at == 14, "R2 reset entry edge", fall_at, 14);
        chk(rise_at == len + 3, "R3 release edge", rise_at, len + 3);
        chk(gear_code == 4'd8, "R5 gear back to 8 (R7 writes in reset dropped)", gear_code, 8);
        chk(clk_sel_ext == exp_sel, "R4 select latched", clk_sel_ext, exp_sel);
        pll_off = !exp_sel;
        repeat (3) @(negedge clk);
        chk(clk_sel_ext == exp_sel, "R4 select held", clk_sel_ext, exp_sel);
      end
      repeat (2) @(negedge clk);
    end

    // Power-on reset mid-run, no qualification
    write_gear(4'd4);
    pll_off = 1'b1;
    #2 por_n = 1'b0;
    #1;
    chk(core_rst_n == 1'b0, "R10 asynchronous entry", core_rst_n, 0);
    chk(gear_code == 4'd8, "R10 gear forced", gear_code, 8);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(core_rst_n == 1'b0, "R10 still held", core_rst_n, 0);
    @(negedge clk);
    chk(core_rst_n == 1'b1, "R10 released", core_rst_n, 1);
    chk(clk_sel_ext == 1'b1, "R4 external selected", clk_sel_ext, 1);
    chk(reset_vector == 32'hBFC0_0000, "R8 vector stable", reset_vector, 32'hBFC0_0000);
    finish_run();
  end
endmodule